// File: doc/BRIEF.md
# Dual-Mode Delay Setting Loader

This block holds the 8-bit setting that a downstream programmable delay uses, and offers two ways to load it. A mode input picks the path. In parallel mode the setting is taken from an 8-bit bus through a transparent hold stage gated by a latch-enable input. When latch-enable is low the stage keeps its value. In serial mode two bus pins change role and become a serial clock and a serial data input. Bits are shifted into a staging register, most significant bit first, while latch-enable is high. The staged value becomes the active setting when latch-enable falls.

All control and bus inputs are asynchronous to the system clock. They are passed through a common synchronizer, so the bus, the mode and latch-enable all see the same latency and keep their relative order. The previous content of the staging register leaves on a serial output, most significant bit first. Several units can therefore be chained for programming. Each time the active setting takes a different value, a one-cycle strobe tells the downstream logic.

Top module: `dly_set_loader`

## Requirements
- R1: During and after reset, `setting_o` is 0, `sdo_o` is 0 and `upd_o` is 0, and the staging register holds 0.
- R2: A synchronized `mode_i` of 0 selects parallel loading and 1 selects serial loading. In serial mode, bus values never reach `setting_o` directly.
- R3: In parallel mode with `le_i` high, `setting_o` follows `bus_i`. A bus change appears on `setting_o` after SYNC_STAGES+1 rising clock edges (3 with defaults).
- R4: In parallel mode with `le_i` low, `setting_o` holds and bus changes have no effect.
- R5: In serial mode, the staging register shifts left by one bit on each synchronized rising edge of `bus_i[1]` (serial clock) while `le_i` is high. The incoming bit is `bus_i[0]` (serial data). Serial clock edges while `le_i` is low shift nothing.
- R6: While serial loading is in progress (serial mode, `le_i` high), `setting_o` stays at the last activated value.
- R7: In serial mode, a synchronized high-to-low transition of `le_i` copies the staging register into `setting_o`.
- R8: `sdo_o` always shows the staging register MSB, so the old contents leave MSB first, one bit per shift.
- R9: After 8×N bits have been shifted, the staging register holds the last 8 bits. The first 8×(N-1) bits have left on `sdo_o` in order, behind the 8 old bits.
- R10: `upd_o` is high for exactly the cycle in which `setting_o` first shows a value that differs from the previous one. It stays low when a load writes an unchanged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = parallel loading, 1 = serial loading |
| le_i | input | 1 | Latch-enable (parallel transparency / serial load window) |
| bus_i | input | 8 | Parallel setting bus; bit 1 is serial clock and bit 0 is serial data in serial mode |
| setting_o | output | 8 | Active delay setting |
| sdo_o | output | 1 | Serial output, MSB of staging register |
| upd_o | output | 1 | One-cycle strobe when the active setting changes |

## Verification
The hardest case to reach is a chained transfer in which the old staging contents must come out on `sdo_o` in the right order while `setting_o` stays frozen. The bench first activates a known serial value. It then shifts 16 bits in one load window and samples `sdo_o` before every serial clock edge. This checks the old byte and then the first new byte. The bench also toggles the serial clock with latch-enable low, and reactivates an unchanged value, to show that no shift and no strobe result.

// File: rtl/dly_set_pkg.sv
package dly_set_pkg;
  typedef enum logic {
    LD_PAR = 1'b0,
    LD_SER = 1'b1
  } ld_mode_e;
endpackage

// File: rtl/dly_sync.sv
module dly_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dly_rise.sv
module dly_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/dly_shreg.sv
module dly_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         sdo_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign data_o = sh_q;
  assign sdo_o  = sh_q[W-1];
endmodule

// File: rtl/dly_setting.sv
module dly_setting #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         par_ld_i,
  input  logic [W-1:0] par_d_i,
  input  logic         ser_ld_i,
  input  logic [W-1:0] ser_d_i,
  output logic [W-1:0] set_o,
  output logic         upd_o
);
  logic [W-1:0] set_q, set_nxt;
  logic         upd_q;

  always_comb begin
    set_nxt = set_q;
    if (par_ld_i)      set_nxt = par_d_i;
    else if (ser_ld_i) set_nxt = ser_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
      upd_q <= 1'b0;
    end else begin
      set_q <= set_nxt;
      upd_q <= (set_nxt != set_q);
    end
  end

  assign set_o = set_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/dly_set_loader.sv
module dly_set_loader
  import dly_set_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SCK_IDX     = 1,
  parameter int SDI_IDX     = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         le_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] setting_o,
  output logic         sdo_o,
  output logic         upd_o
);
  localparam int SW = W + 2;

  logic [SW-1:0] raw, syn;
  ld_mode_e      mode_s;
  logic          le_s;
  logic [W-1:0]  bus_s;
  logic [1:0]    edge_src, edge_hit;
  logic          sck_rise, le_fall;
  logic          shift_en, par_ld, ser_ld;
  logic [W-1:0]  sh_data;

  assign raw = {mode_i, le_i, bus_i};

  dly_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign mode_s = ld_mode_e'(syn[W+1]);
  assign le_s   = syn[W];
  assign bus_s  = syn[W-1:0];

  // index 0: serial clock rise, index 1: latch-enable fall
  assign edge_src = {~le_s, bus_s[SCK_IDX]};

  for (genvar e = 0; e < 2; e++) begin : g_edge
    dly_rise u_rise (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (edge_src[e]),
      .rise_o(edge_hit[e])
    );
  end

  assign sck_rise = edge_hit[0];
  assign le_fall  = edge_hit[1];

  assign shift_en = (mode_s == LD_SER) && le_s && sck_rise;
  assign par_ld   = (mode_s == LD_PAR) && le_s;
  assign ser_ld   = (mode_s == LD_SER) && le_fall;

  dly_shreg #(.W(W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .bit_i  (bus_s[SDI_IDX]),
    .data_o (sh_data),
    .sdo_o  (sdo_o)
  );

  dly_setting #(.W(W)) u_setting (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .par_ld_i(par_ld),
    .par_d_i (bus_s),
    .ser_ld_i(ser_ld),
    .ser_d_i (sh_data),
    .set_o   (setting_o),
    .upd_o   (upd_o)
  );
endmodule

// File: rtl/dly_set_loader_chk.sv
module dly_set_loader_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode_s,
  input logic         le_s,
  input logic         le_fall,
  input logic         sck_rise,
  input logic [W-1:0] sh_data,
  input logic [W-1:0] setting_o,
  input logic         upd_o
);
  AST_SER_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && le_s) |=> $stable(setting_o)); // R6

  AST_PAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_s && !le_s) |=> $stable(setting_o)); // R4

  AST_SER_ACTIVATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && le_fall) |=> (setting_o == $past(sh_data))); // R7

  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && le_s && sck_rise) |=> (sh_data[W-1:1] == $past(sh_data[W-2:0]))); // R5

  AST_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_s && le_s && sck_rise) |=> $stable(sh_data)); // R5

  AST_UPD_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (setting_o != $past(setting_o))); // R10

  AST_UPD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(setting_o)); // R10
endmodule

bind dly_set_loader dly_set_loader_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_s   (syn[W+1]),
  .le_s     (le_s),
  .le_fall  (le_fall),
  .sck_rise (sck_rise),
  .sh_data  (sh_data),
  .setting_o(setting_o),
  .upd_o    (upd_o)
);

// File: tb/dly_set_loader_tb.sv
`timescale 1ns/1ps
module dly_set_loader_tb;
  localparam int W    = 8;
  localparam int SYNC = 2;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0;
  logic         le_i = 1'b0;
  logic [W-1:0] bus_i = '0;
  logic [W-1:0] setting_o;
  logic         sdo_o, upd_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dly_set_loader #(.W(W), .SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .le_i(le_i),
    .bus_i(bus_i), .setting_o(setting_o), .sdo_o(sdo_o), .upd_o(upd_o)
  );

  // behavioural reference: history queue of raw inputs {mode, le, bus}
  logic [W+1:0] hist[$];
  logic [W-1:0] m_sh, m_set;
  logic         m_upd;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {};
      for (int i = 0; i <= SYNC; i++) hist.push_back('0);
      m_sh = '0; m_set = '0; m_upd = 1'b0;
    end else begin
      logic [W+1:0] cur, prv;
      logic [W-1:0] nset;
      bit rise, fall;
      cur  = hist[SYNC-1];
      prv  = hist[SYNC];
      rise = cur[1] && !prv[1];
      fall = !cur[W] && prv[W];
      nset = m_set;
      if (!cur[W+1] && cur[W]) nset = cur[W-1:0];
      else if (cur[W+1] && fall) nset = m_sh;
      if (cur[W+1] && cur[W] && rise) m_sh = {m_sh[W-2:0], cur[0]};
      m_upd = (nset != m_set);
      m_set = nset;
      hist.push_front({mode_i, le_i, bus_i});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_cmp++;
      if (setting_o !== m_set || sdo_o !== m_sh[W-1] || upd_o !== m_upd) begin
        n_bad++;
        $display("FAIL R3/R5/R7/R8/R10 model: act set=%0h sdo=%0b upd=%0b exp set=%0h sdo=%0b upd=%0b",
                 setting_o, sdo_o, upd_o, m_set, m_sh[W-1], m_upd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cnt_upd(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (upd_o) c++;
    end
  endtask

  // one serial bit; returns sdo sampled before the serial clock rises
  task automatic ser_bit(input logic b, output logic so);
    bus_i[0] = b; bus_i[1] = 1'b0;
    cyc(4);
    so = sdo_o;
    bus_i[1] = 1'b1;
    cyc(4);
    bus_i[1] = 1'b0;
  endtask

  task automatic ser_byte(input logic [W-1:0] v, output logic [W-1:0] seen);
    for (int i = W-1; i >= 0; i--) begin
      logic so;
      ser_bit(v[i], so);
      seen[i] = so;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    logic [W-1:0] seen;
    cyc(3);
    chk("R1 setting in reset", setting_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    cyc(2);
    chk("R1 setting after reset", setting_o, 0);
    chk("R1 sdo after reset", sdo_o, 0);
    chk("R1 upd after reset", upd_o, 0);

    // parallel transparent path and latency
    mode_i = 1'b0; le_i = 1'b1; bus_i = 8'hA5;
    cyc(2);
    chk("R3 latency old value", setting_o, 0);
    cyc(1);
    chk("R3 follow bus", setting_o, 8'hA5);
    chk("R10 strobe on change", upd_o, 1);
    cyc(1);
    chk("R10 strobe one cycle", upd_o, 0);

    le_i = 1'b0;
    cyc(4);
    bus_i = 8'h3C;
    cnt_upd(6, c);
    chk("R4 hold with le low", setting_o, 8'hA5);
    chk("R4 no strobe with le low", c, 0);

    le_i = 1'b1;
    cyc(5);
    chk("R3 follow after reopen", setting_o, 8'h3C);
    for (int i = 0; i < 20; i++) begin
      bus_i = 8'(i * 37 + 11);
      cyc(1 + (i % 3));
    end
    bus_i = 8'h3C;
    cyc(5);
    chk("R3 follow final", setting_o, 8'h3C);
    chk("R5 no shift in parallel mode", sdo_o, 0);

    // serial mode
    bus_i = 8'h00; mode_i = 1'b1;
    cyc(5);
    bus_i = 8'hF0;
    cyc(5);
    chk("R2 serial mode ignores bus", setting_o, 8'h3C);
    bus_i = 8'h00;
    cyc(3);
    ser_byte(8'h96, seen);
    chk("R8 old zeros shifted out", seen, 8'h00);
    chk("R6 frozen during load", setting_o, 8'h3C);
    le_i = 1'b0;
    cnt_upd(6, c);
    chk("R7 activate on le fall", setting_o, 8'h96);
    chk("R10 single strobe on activation", c, 1);
    chk("R8 sdo shows MSB", sdo_o, 1);

    // serial clock with le low: no shift
    for (int i = 0; i < 3; i++) begin
      logic so;
      ser_bit(1'b0, so);
    end
    le_i = 1'b1;
    cyc(5);
    le_i = 1'b0;
    cnt_upd(6, c);
    chk("R5 no shift with le low", setting_o, 8'h96);
    chk("R10 no strobe on equal value", c, 0);

    // chained transfer of two bytes
    le_i = 1'b1;
    cyc(5);
    ser_byte(8'h5A, seen);
    chk("R8 old byte out MSB first", seen, 8'h96);
    ser_byte(8'hC3, seen);
    chk("R9 first byte passes to next unit", seen, 8'h5A);
    chk("R6 frozen during long load", setting_o, 8'h96);
    le_i = 1'b0;
    cyc(6);
    chk("R9 last byte stays", setting_o, 8'hC3);

    // back to parallel
    mode_i = 1'b0; bus_i = 8'h77;
    cyc(6);
    chk("R4 parallel le low after serial", setting_o, 8'hC3);
    le_i = 1'b1;
    cyc(6);
    chk("R2 parallel selected again", setting_o, 8'h77);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule